// File: doc/BRIEF.md
# Machine Check Bank Logger

This block keeps the error log of a processor's machine-check architecture. It holds a configurable number of error banks, each a set of four 64-bit registers (control, status, address and miscellaneous), plus one global status word. An inject strobe presents a candidate error record, and the block decides in a single cycle what to do with it. It may refuse the record, drop it because an earlier machine check is still being handled, suppress it because reporting is disabled, escalate it to a processor reset, or write it into the bank it names.

The rules depend on the error class. Uncorrected errors pass through the global and per-bank control gates and can escalate to a reset. Corrected errors are never allowed to replace a logged uncorrected error. When a record lands on a bank that already holds a valid log, the overflow flag is raised so that the earlier loss stays visible. The outcome is reported on a result code and two single-cycle pulses. The register file can be read through a combinational port. A small write port lets handler code set control words and clear logs.

Top module: `mc_bank_logger`

## Requirements
- R1: After reset every bank control register reads all ones. Every bank status, address and misc register reads zero. The global status reads zero, the result code is 0, and both pulses are low.
- R2: An injection is refused with result 1 and no register changes when any of these holds: the capability word is zero, the bank number is not below capability bits [7:0], the bank number is not below NBANKS, or status bit 63 (valid) is clear.
- R3: While global status bit 2 (in-progress) is set, an injection whose status bit 55 (action required) is clear is dropped with result 2, unless the unconditional input is high.
- R4: An uncorrected injection (status bit 61 set) is suppressed with result 3 when capability bit 8 is set and the global control word is not all ones. With capability bit 8 clear, the global control word has no effect.
- R5: An uncorrected injection is suppressed with result 3 when the addressed bank's control register is not all ones.
- R6: An uncorrected injection that passes both control gates requests a reset when the machine-check enable input is low or global status bit 2 is set. The request is result 4 plus a one-cycle reset_req pulse, and nothing is logged.
- R7: Otherwise an uncorrected injection is logged with result 5. Its status, address and misc go into the bank, and its global status word goes into the global status. Status bit 62 (overflow) is set when the previous bank status had bit 63 set. mce_irq pulses for one cycle.
- R8: A corrected injection (bit 61 clear) is logged with result 6, writing status, address and misc, when the previous bank status is not both valid and uncorrected. Bit 62 is set when the previous status was valid.
- R9: A corrected injection that meets a bank holding a valid uncorrected log gives result 7. Only bit 62 of that bank's status is set; address and misc are kept.
- R10: wr_en writes wr_data to the register that wr_sel picks (0 control, 1 status, 2 address, 3 misc, 4 global status) of bank wr_bank. A write in a cycle where inj_valid is high has no effect.
- R11: The result code, mce_irq and reset_req appear in the cycle after the injection and last exactly one cycle. With no injection the result code is 0 (none).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inj_valid | input | 1 | Injection strobe |
| inj_bank | input | 8 | Target bank number |
| inj_status | input | 64 | Candidate bank status word |
| inj_gstatus | input | 64 | Global status to load on an uncorrected log |
| inj_addr | input | 64 | Error address |
| inj_misc | input | 64 | Error auxiliary data |
| inj_uncond | input | 1 | Bypass the in-progress drop rule |
| cap_word | input | 64 | Capability: bank count in [7:0], global-control-present in bit 8 |
| gctl_word | input | 64 | Global control word |
| mce_enable | input | 1 | Machine-check exceptions enabled |
| wr_en | input | 1 | Register write strobe |
| wr_bank | input | 8 | Bank for register write |
| wr_sel | input | 3 | Register select for write |
| wr_data | input | 64 | Write data |
| rd_bank | input | 8 | Bank for read |
| rd_sel | input | 2 | Register select for read (0 ctl, 1 status, 2 addr, 3 misc) |
| rd_data | output | 64 | Read data |
| gstat | output | 64 | Global status register |
| inj_result | output | 3 | Outcome code of the previous cycle's injection |
| mce_irq | output | 1 | Machine-check interrupt pulse |
| reset_req | output | 1 | Reset-request pulse |

## Verification
The state hardest to reach is a bank holding a valid uncorrected log while the in-progress bit is still set. Only from there can the reset escalation, the in-progress drop, the unconditional bypass and the overflow-only case be told apart. The directed part builds that state step by step with an uncorrected log and then sends corrected and uncorrected follow-ups, with and without the bypass flag. The random phase clears global status and bank logs now and then through the write port, so these overlaps keep recurring against a bench model of the file.

// File: rtl/mcbl_pkg.sv
package mcbl_pkg;

    localparam int WORD_W   = 64;
    localparam int VAL_BIT  = 63;
    localparam int OVER_BIT = 62;
    localparam int UC_BIT   = 61;
    localparam int AR_BIT   = 55;
    localparam int MCIP_BIT = 2;
    localparam int CTLP_BIT = 8;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        RES_NONE      = 3'd0,
        RES_REJECT    = 3'd1,
        RES_IGNORE    = 3'd2,
        RES_GATED     = 3'd3,
        RES_RESET     = 3'd4,
        RES_LOG_UC    = 3'd5,
        RES_LOG_CE    = 3'd6,
        RES_OVER_ONLY = 3'd7
    } result_e;

    typedef enum logic [2:0] {
        SEL_CTL    = 3'd0,
        SEL_STATUS = 3'd1,
        SEL_ADDR   = 3'd2,
        SEL_MISC   = 3'd3,
        SEL_GSTAT  = 3'd4
    } sel_e;

    typedef struct packed {
        word_t ctl;
        word_t status;
        word_t addr;
        word_t misc;
    } bank_t;

    typedef struct packed {
        result_e res;
        logic    wr_full;    // status, addr and misc
        logic    wr_status;  // status only
        logic    wr_gstat;
        word_t   status;
    } verdict_t;

    function automatic logic all_ones(word_t w);
        return &w;
    endfunction

    function automatic word_t with_over(word_t s, logic cond);
        word_t r;
        r = s;
        if (cond) r[OVER_BIT] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/mcbl_judge.sv
module mcbl_judge
    import mcbl_pkg::*;
#(
    parameter int NBANKS = 10
) (
    input  logic     inj_valid,
    input  logic [7:0] inj_bank,
    input  word_t    inj_status,
    input  logic     inj_uncond,
    input  word_t    cap_word,
    input  word_t    gctl_word,
    input  logic     mce_enable,
    input  logic     mcip,
    input  word_t    bank_ctl,
    input  word_t    bank_status,
    output verdict_t verdict
);
    localparam logic [7:0] NB8 = 8'(NBANKS);

    logic in_range;
    logic old_val;
    logic old_uc;
    logic gate_closed;

    assign in_range    = (cap_word != '0) && (inj_bank < cap_word[7:0]) && (inj_bank < NB8);
    assign old_val     = bank_status[VAL_BIT];
    assign old_uc      = bank_status[UC_BIT];
    assign gate_closed = (cap_word[CTLP_BIT] && !all_ones(gctl_word)) || !all_ones(bank_ctl);

    always_comb begin
        verdict           = '0;
        verdict.res       = RES_NONE;
        verdict.status    = inj_status;
        if (!inj_valid) begin
            verdict.res = RES_NONE;
        end else if (!in_range || !inj_status[VAL_BIT]) begin
            verdict.res = RES_REJECT;
        end else if (!inj_uncond && !inj_status[AR_BIT] && mcip) begin
            verdict.res = RES_IGNORE;
        end else if (inj_status[UC_BIT]) begin
            if (gate_closed) begin
                verdict.res = RES_GATED;
            end else if (!mce_enable || mcip) begin
                verdict.res = RES_RESET;
            end else begin
                verdict.res      = RES_LOG_UC;
                verdict.wr_full  = 1'b1;
                verdict.wr_gstat = 1'b1;
                verdict.status   = with_over(inj_status, old_val);
            end
        end else if (!old_val || !old_uc) begin
            verdict.res     = RES_LOG_CE;
            verdict.wr_full = 1'b1;
            verdict.status  = with_over(inj_status, old_val);
        end else begin
            verdict.res       = RES_OVER_ONLY;
            verdict.wr_status = 1'b1;
            verdict.status    = with_over(bank_status, 1'b1);
        end
    end

endmodule

// File: rtl/mcbl_bank_file.sv
module mcbl_bank_file
    import mcbl_pkg::*;
#(
    parameter int NBANKS = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       upd_en,
    input  logic       upd_full,
    input  logic [7:0] upd_bank,
    input  word_t      upd_status,
    input  word_t      upd_addr,
    input  word_t      upd_misc,
    input  logic       sw_en,
    input  logic [7:0] sw_bank,
    input  sel_e       sw_sel,
    input  word_t      sw_data,
    input  logic [7:0] look_bank,
    output word_t      look_ctl,
    output word_t      look_status,
    input  logic [7:0] rd_bank,
    input  logic [1:0] rd_sel,
    output word_t      rd_data
);
    bank_t bank_vec [NBANKS];

    for (genvar g = 0; g < NBANKS; g++) begin : g_bank
        bank_t r;
        always_ff @(posedge clk) begin
            if (rst) begin
                r.ctl    <= '1;
                r.status <= '0;
                r.addr   <= '0;
                r.misc   <= '0;
            end else if (upd_en && upd_bank == 8'(g)) begin
                r.status <= upd_status;
                if (upd_full) begin
                    r.addr <= upd_addr;
                    r.misc <= upd_misc;
                end
            end else if (sw_en && sw_bank == 8'(g)) begin
                case (sw_sel)
                    SEL_CTL:    r.ctl    <= sw_data;
                    SEL_STATUS: r.status <= sw_data;
                    SEL_ADDR:   r.addr   <= sw_data;
                    SEL_MISC:   r.misc   <= sw_data;
                    default:    ;
                endcase
            end
        end
        assign bank_vec[g] = r;
    end

    bank_t look_b;
    bank_t rd_b;

    always_comb begin
        look_b = '0;
        rd_b   = '0;
        for (int i = 0; i < NBANKS; i++) begin
            if (look_bank == 8'(i)) look_b = bank_vec[i];
            if (rd_bank == 8'(i))   rd_b   = bank_vec[i];
        end
    end

    assign look_ctl    = look_b.ctl;
    assign look_status = look_b.status;

    always_comb begin
        case (rd_sel)
            2'd0:    rd_data = rd_b.ctl;
            2'd1:    rd_data = rd_b.status;
            2'd2:    rd_data = rd_b.addr;
            default: rd_data = rd_b.misc;
        endcase
    end

endmodule

// File: rtl/mc_bank_logger.sv
module mc_bank_logger
    import mcbl_pkg::*;
#(
    parameter int NBANKS = 10   // 1 to 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        inj_valid,
    input  logic [7:0]  inj_bank,
    input  logic [63:0] inj_status,
    input  logic [63:0] inj_gstatus,
    input  logic [63:0] inj_addr,
    input  logic [63:0] inj_misc,
    input  logic        inj_uncond,
    input  logic [63:0] cap_word,
    input  logic [63:0] gctl_word,
    input  logic        mce_enable,
    input  logic        wr_en,
    input  logic [7:0]  wr_bank,
    input  logic [2:0]  wr_sel,
    input  logic [63:0] wr_data,
    input  logic [7:0]  rd_bank,
    input  logic [1:0]  rd_sel,
    output logic [63:0] rd_data,
    output logic [63:0] gstat,
    output logic [2:0]  inj_result,
    output logic        mce_irq,
    output logic        reset_req
);
    verdict_t verdict;
    word_t    look_ctl;
    word_t    look_status;
    word_t    gstat_q;
    result_e  res_q;
    logic     irq_q;
    logic     rreq_q;
    logic     sw_ok;
    sel_e     sw_sel;

    // Handler writes lose to an injection in the same cycle.
    assign sw_ok  = wr_en && !inj_valid;
    assign sw_sel = sel_e'(wr_sel);

    mcbl_judge #(.NBANKS(NBANKS)) i_judge (
        .inj_valid   (inj_valid),
        .inj_bank    (inj_bank),
        .inj_status  (inj_status),
        .inj_uncond  (inj_uncond),
        .cap_word    (cap_word),
        .gctl_word   (gctl_word),
        .mce_enable  (mce_enable),
        .mcip        (gstat_q[MCIP_BIT]),
        .bank_ctl    (look_ctl),
        .bank_status (look_status),
        .verdict     (verdict)
    );

    mcbl_bank_file #(.NBANKS(NBANKS)) i_banks (
        .clk         (clk),
        .rst         (rst),
        .upd_en      (verdict.wr_full || verdict.wr_status),
        .upd_full    (verdict.wr_full),
        .upd_bank    (inj_bank),
        .upd_status  (verdict.status),
        .upd_addr    (inj_addr),
        .upd_misc    (inj_misc),
        .sw_en       (sw_ok && sw_sel != SEL_GSTAT),
        .sw_bank     (wr_bank),
        .sw_sel      (sw_sel),
        .sw_data     (wr_data),
        .look_bank   (inj_bank),
        .look_ctl    (look_ctl),
        .look_status (look_status),
        .rd_bank     (rd_bank),
        .rd_sel      (rd_sel),
        .rd_data     (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gstat_q <= '0;
            res_q   <= RES_NONE;
            irq_q   <= 1'b0;
            rreq_q  <= 1'b0;
        end else begin
            res_q  <= verdict.res;
            irq_q  <= (verdict.res == RES_LOG_UC);
            rreq_q <= (verdict.res == RES_RESET);
            if (verdict.wr_gstat) begin
                gstat_q <= inj_gstatus;
            end else if (sw_ok && sw_sel == SEL_GSTAT) begin
                gstat_q <= wr_data;
            end
        end
    end

    assign gstat      = gstat_q;
    assign inj_result = res_q;
    assign mce_irq    = irq_q;
    assign reset_req  = rreq_q;

endmodule

// File: rtl/mcbl_checker.sv
module mcbl_checker (
    input logic        clk,
    input logic        rst,
    input logic        inj_valid,
    input logic [63:0] inj_status,
    input logic [63:0] inj_gstatus,
    input logic        mce_enable,
    input logic        wr_en,
    input logic [63:0] gstat,
    input logic [2:0]  inj_result,
    input logic        mce_irq,
    input logic        reset_req
);
    assert_pulses_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(mce_irq && reset_req));

    assert_reset_cause_R6: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> $past(!mce_enable || gstat[2]));

    assert_irq_from_uc_R7: assert property (@(posedge clk) disable iff (rst)
        mce_irq |-> $past(inj_valid && inj_status[61]));

    assert_gstat_loaded_R7: assert property (@(posedge clk) disable iff (rst)
        (inj_result == 3'd5) |-> (gstat == $past(inj_gstatus)));

    assert_refused_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (inj_result inside {3'd1, 3'd2, 3'd3}) |-> (!mce_irq && !reset_req));

    assert_gstat_held_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(inj_valid) && !$past(wr_en)) |-> $stable(gstat));

    assert_idle_result_R11: assert property (@(posedge clk) disable iff (rst)
        !$past(inj_valid) |-> (inj_result == 3'd0));

endmodule

bind mc_bank_logger mcbl_checker i_chk (.*);

// File: tb/test_mc_bank_logger.sv
module test_mc_bank_logger;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 10;
    localparam logic [63:0] VAL  = 64'h8000_0000_0000_0000;
    localparam logic [63:0] OVER = 64'h4000_0000_0000_0000;
    localparam logic [63:0] UC   = 64'h2000_0000_0000_0000;
    localparam logic [63:0] AR   = 64'h0080_0000_0000_0000;
    localparam logic [63:0] ONES = '1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        inj_valid = 1'b0;
    logic [7:0]  inj_bank = '0;
    logic [63:0] inj_status = '0, inj_gstatus = '0, inj_addr = '0, inj_misc = '0;
    logic        inj_uncond = 1'b0;
    logic [63:0] cap_word = 64'(NB);
    logic [63:0] gctl_word = '1;
    logic        mce_enable = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_bank = '0;
    logic [2:0]  wr_sel = '0;
    logic [63:0] wr_data = '0;
    logic [7:0]  rd_bank = '0;
    logic [1:0]  rd_sel = '0;
    logic [63:0] rd_data, gstat;
    logic [2:0]  inj_result;
    logic        mce_irq, reset_req;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    logic [63:0] m_ctl [NB];
    logic [63:0] m_st  [NB];
    logic [63:0] m_ad  [NB];
    logic [63:0] m_mi  [NB];
    logic [63:0] m_gs;

    always #(CLK_PERIOD/2) clk = ~clk;

    mc_bank_logger #(.NBANKS(NB)) i_mc_bank_logger (.*);

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    // Expected outcome from the requirements; updates the bench model.
    task automatic model_step(input logic [7:0] b, input logic [63:0] st, gs, ad, mi,
                              input logic un, output logic [2:0] r);
        if (cap_word == 0 || b >= cap_word[7:0] || b >= 8'(NB) || !st[63]) r = 3'd1;        // R2
        else if (!un && !st[55] && m_gs[2]) r = 3'd2;                                       // R3
        else if (st[61]) begin
            if ((cap_word[8] && gctl_word != ONES) || m_ctl[b] != ONES) r = 3'd3;           // R4 R5
            else if (!mce_enable || m_gs[2]) r = 3'd4;                                      // R6
            else begin                                                                      // R7
                r = 3'd5;
                m_st[b] = st | (m_st[b][63] ? OVER : 64'h0);
                m_ad[b] = ad; m_mi[b] = mi; m_gs = gs;
            end
        end else if (!m_st[b][63] || !m_st[b][61]) begin                                    // R8
            r = 3'd6;
            m_st[b] = st | (m_st[b][63] ? OVER : 64'h0);
            m_ad[b] = ad; m_mi[b] = mi;
        end else begin                                                                      // R9
            r = 3'd7;
            m_st[b] = m_st[b] | OVER;
        end
    endtask

    task automatic verify_bank(input logic [7:0] b, input string req);
        if (b < 8'(NB)) begin
            for (int s = 0; s < 4; s++) begin
                rd_bank = b; rd_sel = 2'(s); #1;
                case (s)
                    0: chk(req, "ctl", rd_data, m_ctl[b]);
                    1: chk(req, "status", rd_data, m_st[b]);
                    2: chk(req, "addr", rd_data, m_ad[b]);
                    default: chk(req, "misc", rd_data, m_mi[b]);
                endcase
            end
        end
        chk(req, "gstat", gstat, m_gs);
    endtask

    task automatic inject(input logic [7:0] b, input logic [63:0] st, gs, ad, mi,
                          input logic un, input string req);
        logic [2:0] er;
        @(negedge clk);
        inj_valid = 1; inj_bank = b; inj_status = st; inj_gstatus = gs;
        inj_addr = ad; inj_misc = mi; inj_uncond = un;
        model_step(b, st, gs, ad, mi, un, er);
        @(negedge clk);
        inj_valid = 0;
        chk(req, "result", 64'(inj_result), 64'(er));
        chk(req, "mce_irq", 64'(mce_irq), 64'(er == 3'd5));
        chk(req, "reset_req", 64'(reset_req), 64'(er == 3'd4));
        verify_bank(b, req);
    endtask

    task automatic sw_write(input logic [7:0] b, input logic [2:0] sel, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1; wr_bank = b; wr_sel = sel; wr_data = d;
        if (sel == 3'd4) m_gs = d;
        else if (b < 8'(NB)) begin
            case (sel)
                3'd0: m_ctl[b] = d;
                3'd1: m_st[b] = d;
                3'd2: m_ad[b] = d;
                3'd3: m_mi[b] = d;
                default: ;
            endcase
        end
        @(negedge clk);
        wr_en = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NB; i++) begin
            m_ctl[i] = ONES; m_st[i] = 0; m_ad[i] = 0; m_mi[i] = 0;
        end
        m_gs = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        chk("R1", "result", 64'(inj_result), 0);
        chk("R1", "pulses", 64'({mce_irq, reset_req}), 0);
        for (int b = 0; b < NB; b++) verify_bank(8'(b), "R1");

        // R2 refusals
        inject(8'(NB), VAL, 0, 1, 1, 0, "R2");
        inject(3, 64'h0000_00AB, 0, 1, 1, 0, "R2");
        cap_word = 64'd4;
        inject(5, VAL, 0, 1, 1, 0, "R2");
        cap_word = 0;
        inject(0, VAL, 0, 1, 1, 0, "R2");
        cap_word = 64'(NB);

        // R8 corrected logs and overflow
        inject(1, VAL | 64'h11, 0, 64'hA1, 64'hB1, 0, "R8");
        inject(1, VAL | 64'h22, 0, 64'hA2, 64'hB2, 0, "R8");

        // R7 uncorrected log, R11 pulse width
        inject(2, VAL | UC | 64'h33, 64'h5, 64'hC3, 64'hD3, 0, "R7");
        @(negedge clk);
        chk("R11", "result idle", 64'(inj_result), 0);
        chk("R11", "irq idle", 64'(mce_irq), 0);

        // R3 drop while in progress, bypass, R9 overflow only
        inject(2, VAL | 64'h44, 0, 64'hE4, 64'hF4, 0, "R3");
        inject(2, VAL | 64'h44, 0, 64'hE4, 64'hF4, 1, "R9");
        inject(4, VAL | AR | 64'h55, 0, 64'h15, 64'h16, 0, "R3");
        // R6 reset while in progress
        inject(3, VAL | UC | AR, 64'h4, 1, 2, 0, "R6");
        // R10 clear global status, then disable
        sw_write(0, 3'd4, 0);
        chk("R10", "gstat", gstat, 0);
        mce_enable = 0;
        inject(3, VAL | UC, 64'h4, 1, 2, 0, "R6");
        mce_enable = 1;

        // R4 global gate
        cap_word = 64'h100 | 64'(NB); gctl_word = 64'hFFFF_FFFF_FFFF_FFFE;
        inject(5, VAL | UC, 64'h4, 7, 8, 0, "R4");
        cap_word = 64'(NB);
        inject(5, VAL | UC, 64'h4, 7, 8, 0, "R4");
        gctl_word = ONES;
        sw_write(0, 3'd4, 0);

        // R5 bank gate
        sw_write(6, 3'd0, 64'h0);
        inject(6, VAL | UC, 64'h4, 9, 9, 0, "R5");
        sw_write(6, 3'd0, ONES);

        // R10 write blocked by same-cycle injection
        @(negedge clk);
        wr_en = 1; wr_bank = 7; wr_sel = 3'd2; wr_data = 64'hDEAD;
        inj_valid = 1; inj_bank = 8'(NB); inj_status = VAL;
        @(negedge clk);
        wr_en = 0; inj_valid = 0;
        verify_bank(7, "R10");
        sw_write(7, 3'd3, 64'hBEEF);
        verify_bank(7, "R10");

        // random phase
        for (int n = 0; n < 400; n++) begin
            logic [63:0] st;
            int k;
            k = int'($urandom_range(0, 99));
            if (k < 12) sw_write(0, 3'd4, 0);
            else if (k < 20) sw_write(8'($urandom_range(0, NB-1)), 3'd1, 0);
            else if (k < 23) sw_write(8'($urandom_range(0, NB-1)), 3'd0,
                                      ($urandom_range(0, 1) != 0) ? ONES : 64'h0F);
            k = int'($urandom_range(0, 99));
            cap_word = (k < 85) ? (64'(NB) | (64'($urandom_range(0, 1)) << 8))
                     : ((k < 95) ? 64'($urandom_range(1, NB)) : 64'h0);
            gctl_word = ($urandom_range(0, 9) == 0) ? 64'h7 : ONES;
            mce_enable = ($urandom_range(0, 9) != 0);
            st = {32'($urandom), 32'($urandom)} & 64'h007F_FFFF_FFFF_FFFF;
            if ($urandom_range(0, 9) != 0) st |= VAL;
            if ($urandom_range(0, 1) != 0) st |= UC;
            if ($urandom_range(0, 2) == 0) st |= AR;
            inject(8'($urandom_range(0, NB + 1)), st,
                   64'($urandom_range(0, 7)), {32'($urandom), 32'($urandom)},
                   {32'($urandom), 32'($urandom)}, $urandom_range(0, 3) == 0,
                   "R2 R3 R5 R6 R7 R8 R9 random");
        end

        summary();
    end

endmodule